// File: doc/BRIEF.md
# Instruction Address Compare Debug Unit

This block watches the stream of instruction addresses a core fetches or retires, and raises a debug event whenever an address hits one of three programmable watch points. Software programs a control register and three address-compare registers through a simple register port, where each register is selected by a number. Each watch point can be limited to a privilege state (supervisor or problem state) and to one instruction address space.

Watch points 1 and 2 can also be joined into one masked watch point. In that joined mode, register 1 holds the target address and register 2 holds a care mask, so one event covers a whole family of addresses. Instructions are word aligned, so the two low address bits never take part in a compare. Each event is a one-cycle pulse that appears in the cycle after the instruction address is presented.

Top module: `iac_debug_unit`

## Requirements
- R1: After reset, the control register and all three compare registers read as zero and no event output is asserted.
- R2: Register number 309 selects the control register, and numbers 312, 313 and 314 select compare registers 1, 2 and 3. A write is stored at the next clock edge, and a read returns the value in the same cycle. Any other number reads as zero, and a write to it changes no register.
- R3: The control register layout (bit 0 is the least significant bit) is as follows. Watch point n (n = 0, 1, 2 for watch points 1, 2, 3) has its privilege qualifier at bits 4n+1:4n and its space qualifier at bits 4n+3:4n+2. Bit 16 is the pairing bit. All other bits ignore writes and read as zero.
- R4: In exact mode, watch point n raises evt[n-1] in the cycle after ia_valid is sampled high with address bits [W-1:2] equal to those of compare register n. The pulse lasts one cycle. Address bits 1:0 are ignored, and no event follows a cycle with ia_valid low.
- R5: Privilege qualifier code 00 allows an event in either privilege state. Code 10 allows it only when ia_pr is 0, and code 11 only when ia_pr is 1.
- R6: Space qualifier code 00 allows an event in either address space. Code 10 allows it only when ia_is is 0, and code 11 only when ia_is is 1.
- R7: A qualifier field holding code 01 blocks every event from its watch point.
- R8: With the pairing bit set, evt[0] fires when ((ia_addr XOR compare1) AND compare2) is zero in bits [W-1:2], using the qualifiers of watch point 1. evt[1] stays low, and watch point 3 keeps exact compare.
- R9: Several watch points that hit on the same address raise their events in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_en | input | 1 | Register write strobe |
| reg_num | input | NUM_W | Register number for reads and writes |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for reg_num (combinational) |
| ia_valid | input | 1 | Instruction address valid |
| ia_addr | input | W | Instruction address |
| ia_pr | input | 1 | Problem-state bit (1 = user) |
| ia_is | input | 1 | Instruction address-space bit |
| evt | output | 3 | Registered per-watch-point event pulses, bit n for watch point n+1 |

## Verification
The bench builds the block with its default parameters: W = 64, NUM_W = 10, and a control register at 309 with compare registers from 312. The full 64-bit width lets the bench place the compare targets and masks in the top address bits. It can then show that the exact compare and the masked compare both reach the most significant bits while bits 1:0 are ignored. The 10-bit register number reaches both the mapped registers and unmapped numbers, so stray writes and reads can be checked.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int NUM_LANES  = 3;
  localparam int CTRL_W     = 32;
  localparam int PAIR_BIT   = 16;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 32'h0001_0FFF;

  localparam logic [1:0] Q_ANY  = 2'b00;
  localparam logic [1:0] Q_RSVD = 2'b01;
  localparam logic [1:0] Q_ZERO = 2'b10;
  localparam logic [1:0] Q_ONE  = 2'b11;

  // One qualifier field against its state bit
  function automatic logic field_pass(input logic [1:0] code, input logic state);
    logic ok;
    case (code)
      Q_ANY:   ok = 1'b1;
      Q_ZERO:  ok = ~state;
      Q_ONE:   ok = state;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/iac_rst_sync.sv
module iac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/iac_regs.sv
module iac_regs
  import iac_pkg::*;
#(
  parameter int W        = 64,
  parameter int NUM_W    = 10,
  parameter int CTRL_NUM = 309,
  parameter int CMP_BASE = 312
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [NUM_W-1:0]       num,
  input  logic [W-1:0]           wdata,
  output logic [W-1:0]           rdata,
  output logic [CTRL_W-1:0]      ctrl,
  output logic [NUM_LANES*W-1:0] cmp_flat
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_we;
  logic [NUM_LANES-1:0] cmp_we;
  logic [W-1:0] cmp_q [NUM_LANES];
  logic mapped;

  assign ctrl_we = wr_en && (num == NUM_W'(CTRL_NUM));
  assign ctrl_d  = wdata[CTRL_W-1:0] & CTRL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_cmp
    assign cmp_we[i] = wr_en && (num == NUM_W'(CMP_BASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cmp_q[i] <= '0;
      else if (cmp_we[i]) cmp_q[i] <= wdata;
    end
    assign cmp_flat[i*W +: W] = cmp_q[i];
  end

  always_comb begin
    rdata  = '0;
    mapped = 1'b0;
    if (num == NUM_W'(CTRL_NUM)) begin
      rdata  = W'(ctrl_q);
      mapped = 1'b1;
    end
    for (int i = 0; i < NUM_LANES; i++) begin
      if (num == NUM_W'(CMP_BASE + i)) begin
        rdata  = cmp_q[i];
        mapped = 1'b1;
      end
    end
  end

  assign ctrl = ctrl_q;

  AST_CTRL_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (num == NUM_W'(CTRL_NUM)) |-> ((rdata[CTRL_W-1:0] & ~CTRL_MASK) == '0)); // R3
  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> ($stable(ctrl_q) && $stable(cmp_flat))); // R2
endmodule

// File: rtl/iac_lane.sv
module iac_lane
  import iac_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-3:0] addr_w,
  input  logic [W-3:0] ref_w,
  input  logic [W-3:0] care_w,
  input  logic [1:0]   priv_q,
  input  logic [1:0]   space_q,
  input  logic         pr,
  input  logic         is,
  input  logic         en,
  output logic         hit
);
  logic [W-3:0] diff;
  logic qual_ok;

  assign diff    = (addr_w ^ ref_w) & care_w;
  assign qual_ok = field_pass(priv_q, pr) && field_pass(space_q, is);
  assign hit     = en && qual_ok && (diff == '0);

  always_comb begin
    if (priv_q == Q_RSVD || space_q == Q_RSVD)
      AST_RSVD_CODE_SILENT: assert (!hit); // R7
  end
endmodule

// File: rtl/iac_debug_unit.sv
module iac_debug_unit
  import iac_pkg::*;
#(
  parameter int W        = 64,
  parameter int NUM_W    = 10,
  parameter int CTRL_NUM = 309,
  parameter int CMP_BASE = 312
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [NUM_W-1:0] reg_num,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  input  logic             ia_valid,
  input  logic [W-1:0]     ia_addr,
  input  logic             ia_pr,
  input  logic             ia_is,
  output logic [2:0]       evt
);
  localparam int WW = W - 2;

  logic srst_n;
  logic [CTRL_W-1:0] ctrl;
  logic [NUM_LANES*W-1:0] cmp_flat;
  logic pair_mode;
  logic [NUM_LANES-1:0] hit, evt_d, evt_q;
  logic unused_lo;

  iac_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  iac_regs #(.W(W), .NUM_W(NUM_W), .CTRL_NUM(CTRL_NUM), .CMP_BASE(CMP_BASE)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(reg_wr_en), .num(reg_num),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl), .cmp_flat(cmp_flat)
  );

  assign pair_mode = ctrl[PAIR_BIT];
  assign unused_lo = ^{ia_addr[1:0], cmp_flat[1:0], cmp_flat[W+1:W], cmp_flat[2*W+1:2*W],
                       ctrl[CTRL_W-1:PAIR_BIT+1], ctrl[PAIR_BIT-1:12]};

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [WW-1:0] ref_w, care_w;
    logic          en;
    if (i == 0) begin : g_first
      assign ref_w  = cmp_flat[W-1:2];
      assign care_w = pair_mode ? cmp_flat[2*W-1:W+2] : '1;
      assign en     = 1'b1;
    end else if (i == 1) begin : g_second
      assign ref_w  = cmp_flat[2*W-1:W+2];
      assign care_w = '1;
      assign en     = ~pair_mode;
    end else begin : g_rest
      assign ref_w  = cmp_flat[i*W+W-1:i*W+2];
      assign care_w = '1;
      assign en     = 1'b1;
    end
    iac_lane #(.W(W)) u_lane (
      .addr_w(ia_addr[W-1:2]), .ref_w(ref_w), .care_w(care_w),
      .priv_q(ctrl[4*i +: 2]), .space_q(ctrl[4*i+2 +: 2]),
      .pr(ia_pr), .is(ia_is), .en(en), .hit(hit[i])
    );
  end

  always_comb begin
    evt_d = ia_valid ? hit : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) evt_q <= '0;
    else         evt_q <= evt_d;
  end

  assign evt = evt_q;

  AST_EVT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!srst_n)
    (evt != 3'b000) |-> $past(ia_valid)); // R4
  AST_PAIR_MUTES_SECOND: assert property (@(posedge clk) disable iff (!srst_n)
    $past(ia_valid && pair_mode) |-> !evt[1]); // R8
endmodule

// File: tb/tb_iac_debug_unit.sv
module tb_iac_debug_unit;
  localparam int CLK_PER = 10;
  localparam int W = 64;
  localparam int NUM_W = 10;
  localparam logic [31:0] MASK = 32'h0001_0FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [NUM_W-1:0] reg_num = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic ia_valid = 1'b0;
  logic [W-1:0] ia_addr = '0;
  logic ia_pr = 1'b0;
  logic ia_is = 1'b0;
  logic [2:0] evt;

  int total = 0;
  int bad = 0;
  logic [31:0] sh_ctrl = '0;
  logic [W-1:0] sh_cmp [3];
  logic [2:0] exp_q [$];
  string tag_q [$];

  always #(CLK_PER/2) clk = ~clk;

  iac_debug_unit dut (.*);

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit qpass(input logic [1:0] c, input logic s);
    return (c == 2'b00) || (c == 2'b10 && !s) || (c == 2'b11 && s);
  endfunction

  function automatic logic [2:0] model(input logic [W-1:0] a, input logic pr, input logic is);
    logic [2:0] e;
    bit pair = sh_ctrl[16];
    for (int i = 0; i < 3; i++) begin
      bit q = qpass(sh_ctrl[4*i +: 2], pr) && qpass(sh_ctrl[4*i+2 +: 2], is);
      bit m = (a[W-1:2] == sh_cmp[i][W-1:2]);
      if (i == 0 && pair) m = (((a ^ sh_cmp[0]) & sh_cmp[1]) >> 2) == 0;
      if (i == 1 && pair) m = 1'b0;
      e[i] = q && m;
    end
    return e;
  endfunction

  task automatic wr(input int num, input logic [W-1:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_num = NUM_W'(num); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (num == 309) sh_ctrl = d[31:0] & MASK;
    else if (num >= 312 && num <= 314) sh_cmp[num-312] = d;
  endtask

  task automatic rd(input int num, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    reg_num = NUM_W'(num);
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic drive(input logic [W-1:0] a, input logic pr, input logic is, input string req);
    @(negedge clk);
    ia_valid = 1'b1; ia_addr = a; ia_pr = pr; ia_is = is;
    exp_q.push_back(model(a, pr, is));
    tag_q.push_back(req);
    @(negedge clk);
    ia_valid = 1'b0;
  endtask

  // Monitor: one result per sampled valid; silence otherwise
  always @(posedge clk) begin : mon
    logic was_v;
    logic [2:0] e;
    string t;
    was_v = ia_valid;
    #(CLK_PER/4);
    if (was_v && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(evt == e, t, W'(evt), W'(e));
    end else begin
      chk(evt == 3'b000, "R4 no event without valid", W'(evt), '0);
    end
  end

  initial begin
    #(CLK_PER*50000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) sh_cmp[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(309, '0, "R1 ctrl reset");
    rd(312, '0, "R1 cmp1 reset");
    rd(313, '0, "R1 cmp2 reset");
    rd(314, '0, "R1 cmp3 reset");
    chk(evt == 3'b000, "R1 evt reset", W'(evt), '0);

    // R2 register access
    wr(312, 64'h8000_0000_0000_1000);
    wr(313, 64'h0000_0000_0000_2000);
    wr(314, 64'hC000_0000_0000_3000);
    rd(312, 64'h8000_0000_0000_1000, "R2 cmp1 readback");
    rd(314, 64'hC000_0000_0000_3000, "R2 cmp3 readback");
    wr(400, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(400, '0, "R2 unmapped reads zero");
    rd(313, 64'h0000_0000_0000_2000, "R2 stray write ignored");
    rd(309, '0, "R2 stray write ctrl");

    // R3 reserved bits
    wr(309, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(309, 64'h0001_0FFF, "R3 reserved bits zero");
    wr(309, 64'h0);

    // R4 exact compare
    drive(64'h8000_0000_0000_1000, 1'b0, 1'b0, "R4 hit cmp1");
    drive(64'h8000_0000_0000_1003, 1'b1, 1'b1, "R4 low bits ignored");
    drive(64'h8000_0000_0000_1004, 1'b0, 1'b0, "R4 miss");
    drive(64'h0000_0000_0000_1000, 1'b0, 1'b0, "R4 msb differs");
    drive(64'h0000_0000_0000_2000, 1'b0, 1'b0, "R4 hit cmp2");
    drive(64'hC000_0000_0000_3002, 1'b0, 1'b0, "R4 hit cmp3");
    repeat (2) @(negedge clk);

    // R9 simultaneous
    wr(314, 64'h8000_0000_0000_1000);
    drive(64'h8000_0000_0000_1000, 1'b0, 1'b0, "R9 two watch points");

    // R5 privilege
    wr(309, 64'h0000_0002);
    drive(64'h8000_0000_0000_1000, 1'b0, 1'b0, "R5 code10 pr0");
    drive(64'h8000_0000_0000_1000, 1'b1, 1'b0, "R5 code10 pr1");
    wr(309, 64'h0000_0003);
    drive(64'h8000_0000_0000_1000, 1'b1, 1'b0, "R5 code11 pr1");
    drive(64'h8000_0000_0000_1000, 1'b0, 1'b0, "R5 code11 pr0");

    // R6 space
    wr(309, 64'h0000_0008);
    drive(64'h8000_0000_0000_1000, 1'b0, 1'b0, "R6 code10 is0");
    drive(64'h8000_0000_0000_1000, 1'b0, 1'b1, "R6 code10 is1");
    wr(309, 64'h0000_0C00);
    drive(64'h8000_0000_0000_1000, 1'b0, 1'b1, "R6 lane3 code11 is1");
    drive(64'h8000_0000_0000_1000, 1'b0, 1'b0, "R6 lane3 code11 is0");

    // R7 reserved codes
    wr(309, 64'h0000_0001);
    drive(64'h8000_0000_0000_1000, 1'b0, 1'b0, "R7 priv code01");
    drive(64'h8000_0000_0000_1000, 1'b1, 1'b1, "R7 priv code01 alt");
    wr(309, 64'h0000_0040);
    drive(64'h0000_0000_0000_2000, 1'b0, 1'b0, "R7 space code01 lane2");

    // R8 pairing
    wr(309, 64'h0001_0000);
    wr(312, 64'h8000_0000_0000_1000);
    wr(313, 64'hF000_0000_0000_FF00);
    wr(314, 64'h0000_0000_0000_5000);
    drive(64'h8ABC_0000_0000_10AB, 1'b0, 1'b0, "R8 masked hit");
    drive(64'h8000_0000_0000_1100, 1'b0, 1'b0, "R8 masked miss low");
    drive(64'h4000_0000_0000_1000, 1'b0, 1'b0, "R8 masked miss high");
    drive(64'hF000_0000_0000_FF00, 1'b0, 1'b0, "R8 cmp2 silent");
    drive(64'h0000_0000_0000_5000, 1'b0, 1'b0, "R8 lane3 exact");
    wr(309, 64'h0001_0002);
    drive(64'h8000_0000_0000_10FF, 1'b1, 1'b0, "R8 uses lane1 qualifier");
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule